// File: doc/BRIEF.md
# Halfword Multiply-Add Unit

This block is an integer datapath for one multiply-add step. It takes one 16-bit half of operand A and one 16-bit half of operand B. Each half is widened to the full word, with or without sign extension. The two are multiplied, and the product may be moved up by one halfword. An addend built from operand C, as picked by a 3-bit addend mode, is then added. One mode corrects C for negative operands and skips that correction whenever either operand half is zero.

A merge option packs the low half of the sum under the low half of operand B. This supports building a wide product out of several halfword passes. Zero, sign, carry and overflow flags come from the final addition and its result. They are written only on request.

The result is registered. An operand set presented with `in_valid` appears on `result` one clock later, with `out_valid` high in that cycle. Because the addition wraps at the word width, the signedness of C would change no result bit, so the block has no input for it.

Top module: `hmad_unit`

## Requirements
- R1: The half of A used is a[W-1:H] when `a_hi` is 1 and a[H-1:0] when it is 0. It is sign-extended to W bits when `a_signed` is 1 and zero-extended when it is 0. B's half is chosen and extended the same way, using `b_hi` and `b_signed`.
- R2: The product is (extended A × extended B) mod 2^W. When `prod_shift` is 1, this product is shifted left by H bits, with the word width kept, before the addition.
- R3: The `c_mode` encodings work as follows:
  - 0 uses C unchanged as the addend.
  - 1 uses c[H-1:0] zero-extended.
  - 2 uses c[W-1:H] zero-extended.
  - 5, 6 and 7 use an addend of zero.
- R4: With `c_mode` = 3, the addend is (C + (b[H-1:0] << H)) mod 2^W. Here b is the full original operand B, whatever `b_hi` selects.
- R5: With `c_mode` = 4, the addend is C when either selected half is zero. Otherwise it is C − k·2^H (mod 2^W), where k (0, 1 or 2) is the number of extended operands whose top bit is 1.
- R6: With `merge` at 0, `result` is the sum. With `merge` at 1, `result` = {b[H-1:0], sum[H-1:0]}.
- R7: When `in_valid` and `flag_we` are both 1, the flags are loaded one cycle later as follows:
  - `flag_z` = (result == 0) and `flag_n` = result[W-1].
  - `flag_c` is the carry out of product + addend.
  - `flag_v` is the signed overflow of that addition: both inputs have the same top bit and the sum's top bit differs.
- R8: When `in_valid` or `flag_we` is 0, all four flags keep their values.
- R9: `out_valid` equals `in_valid` delayed by one clock. When `in_valid` is 0, `result` holds its previous value.
- R10: While `rst_n` is low, `out_valid`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand set valid this cycle |
| a | input | W | Operand A |
| b | input | W | Operand B |
| c | input | W | Operand C |
| a_hi | input | 1 | Use the upper half of A |
| b_hi | input | 1 | Use the upper half of B |
| a_signed | input | 1 | Sign-extend A's half |
| b_signed | input | 1 | Sign-extend B's half |
| prod_shift | input | 1 | Shift the product left by H |
| merge | input | 1 | Pack the low sum half with B's low half |
| c_mode | input | 3 | Addend mode |
| flag_we | input | 1 | Load the flags from this operation |
| out_valid | output | 1 | Result valid |
| result | output | W | Registered result |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Sign flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |

W = 2·H, where H is the parameter `HALF_W` (16 by default).

## Verification
The bench builds the unit with `HALF_W` = 4, which makes the word 8 bits wide. At that size, every pairing of A and B halves can be run through the sign-correction mode. This includes the zero-half suppression and the cases with one and with two negative operands. The same size lets every combination of half selects, signedness, shift and merge be crossed with all eight addend modes. Carry and overflow occur often at 8 bits, so the flag logic is exercised thoroughly rather than hit by chance.

// File: rtl/hmad_pkg.sv
package hmad_pkg;

    localparam int unsigned MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        ADD_PLAIN  = 3'd0,
        ADD_LOW    = 3'd1,
        ADD_HIGH   = 3'd2,
        ADD_BSHIFT = 3'd3,
        ADD_SGNFIX = 3'd4
    } addend_mode_e;

endpackage

// File: rtl/hmad_half_ext.sv
module hmad_half_ext #(
    parameter int unsigned HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] word_i,
    input  logic                hi_i,
    input  logic                sgn_i,
    output logic [HALF_W-1:0]   half_o,
    output logic [2*HALF_W-1:0] ext_o,
    output logic                zero_o,
    output logic                neg_o
);
    localparam int unsigned W = 2 * HALF_W;

    always_comb begin
        half_o = hi_i ? word_i[W-1:HALF_W] : word_i[HALF_W-1:0];
        ext_o  = {{HALF_W{sgn_i & half_o[HALF_W-1]}}, half_o};
        zero_o = (half_o == '0);
        neg_o  = ext_o[W-1];
    end

    // R1
    always_comb begin
        ext_fill_chk: assert ((ext_o[W-1:HALF_W] == '0) || (sgn_i && (ext_o[W-1:HALF_W] == '1)))
            else $error("extension fill bits inconsistent");
    end

endmodule

// File: rtl/hmad_addend.sv
module hmad_addend
    import hmad_pkg::*;
#(
    parameter int unsigned HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] c_i,
    input  logic [HALF_W-1:0]   b_low_i,
    input  logic [MODE_W-1:0]   mode_i,
    input  logic                a_zero_i,
    input  logic                b_zero_i,
    input  logic                a_neg_i,
    input  logic                b_neg_i,
    output logic [2*HALF_W-1:0] addend_o
);
    localparam int unsigned W = 2 * HALF_W;

    logic [1:0]   neg_cnt;
    logic [W-1:0] corr_step;

    always_comb begin
        neg_cnt   = {1'b0, a_neg_i} + {1'b0, b_neg_i};
        corr_step = {{(W-2){1'b0}}, neg_cnt} << HALF_W;
        case (addend_mode_e'(mode_i))
            ADD_PLAIN:  addend_o = c_i;
            ADD_LOW:    addend_o = {{HALF_W{1'b0}}, c_i[HALF_W-1:0]};
            ADD_HIGH:   addend_o = {{HALF_W{1'b0}}, c_i[W-1:HALF_W]};
            ADD_BSHIFT: addend_o = c_i + {b_low_i, {HALF_W{1'b0}}};
            ADD_SGNFIX: addend_o = (a_zero_i || b_zero_i) ? c_i : (c_i - corr_step);
            default:    addend_o = '0;
        endcase
    end

    // R5
    always_comb begin
        if (mode_i == ADD_SGNFIX && !a_neg_i && !b_neg_i) begin
            sgnfix_pass_chk: assert (addend_o == c_i)
                else $error("sign fix altered C with no negative operand");
        end
    end

endmodule

// File: rtl/hmad_sum.sv
module hmad_sum #(
    parameter int unsigned HALF_W = 16
) (
    input  logic [2*HALF_W-1:0] ext_a_i,
    input  logic [2*HALF_W-1:0] ext_b_i,
    input  logic [2*HALF_W-1:0] addend_i,
    input  logic                prod_shift_i,
    input  logic                merge_i,
    input  logic [HALF_W-1:0]   b_low_i,
    output logic [2*HALF_W-1:0] result_o,
    output logic                carry_o,
    output logic                ovf_o
);
    localparam int unsigned W = 2 * HALF_W;

    logic [W-1:0] prod;
    logic [W-1:0] prod_sh;
    logic [W-1:0] sum;

    always_comb begin
        prod           = ext_a_i * ext_b_i;
        prod_sh        = prod_shift_i ? (prod << HALF_W) : prod;
        {carry_o, sum} = {1'b0, prod_sh} + {1'b0, addend_i};
        ovf_o          = (prod_sh[W-1] == addend_i[W-1]) && (sum[W-1] != prod_sh[W-1]);
        result_o       = merge_i ? {b_low_i, sum[HALF_W-1:0]} : sum;
    end

    // R2
    always_comb begin
        if (prod_shift_i && !merge_i) begin
            shift_low_chk: assert (result_o[HALF_W-1:0] == addend_i[HALF_W-1:0])
                else $error("shifted product leaked into low half");
        end
    end

endmodule

// File: rtl/hmad_unit.sv
module hmad_unit
    import hmad_pkg::*;
#(
    parameter int unsigned HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [2*HALF_W-1:0] a,
    input  logic [2*HALF_W-1:0] b,
    input  logic [2*HALF_W-1:0] c,
    input  logic                a_hi,
    input  logic                b_hi,
    input  logic                a_signed,
    input  logic                b_signed,
    input  logic                prod_shift,
    input  logic                merge,
    input  logic [MODE_W-1:0]   c_mode,
    input  logic                flag_we,
    output logic                out_valid,
    output logic [2*HALF_W-1:0] result,
    output logic                flag_z,
    output logic                flag_n,
    output logic                flag_c,
    output logic                flag_v
);
    localparam int unsigned W      = 2 * HALF_W;
    localparam int unsigned N_OPS  = 2;

    typedef struct packed {
        logic         vld;
        logic [W-1:0] res;
        logic         z;
        logic         n;
        logic         c;
        logic         v;
    } state_t;

    state_t state_d, state_q;

    logic [W-1:0]      op_word [N_OPS];
    logic              op_hi   [N_OPS];
    logic              op_sgn  [N_OPS];
    logic [HALF_W-1:0] op_half [N_OPS];
    logic [W-1:0]      op_ext  [N_OPS];
    logic              op_zero [N_OPS];
    logic              op_neg  [N_OPS];

    assign op_word[0] = a;
    assign op_word[1] = b;
    assign op_hi[0]   = a_hi;
    assign op_hi[1]   = b_hi;
    assign op_sgn[0]  = a_signed;
    assign op_sgn[1]  = b_signed;

    for (genvar g = 0; g < N_OPS; g++) begin : g_ext
        hmad_half_ext #(.HALF_W(HALF_W)) i_ext (
            .word_i (op_word[g]),
            .hi_i   (op_hi[g]),
            .sgn_i  (op_sgn[g]),
            .half_o (op_half[g]),
            .ext_o  (op_ext[g]),
            .zero_o (op_zero[g]),
            .neg_o  (op_neg[g])
        );
    end

    logic [W-1:0] addend;
    logic [W-1:0] sum_res;
    logic         sum_carry;
    logic         sum_ovf;

    hmad_addend #(.HALF_W(HALF_W)) i_addend (
        .c_i      (c),
        .b_low_i  (b[HALF_W-1:0]),
        .mode_i   (c_mode),
        .a_zero_i (op_zero[0]),
        .b_zero_i (op_zero[1]),
        .a_neg_i  (op_neg[0]),
        .b_neg_i  (op_neg[1]),
        .addend_o (addend)
    );

    hmad_sum #(.HALF_W(HALF_W)) i_sum (
        .ext_a_i      (op_ext[0]),
        .ext_b_i      (op_ext[1]),
        .addend_i     (addend),
        .prod_shift_i (prod_shift),
        .merge_i      (merge),
        .b_low_i      (b[HALF_W-1:0]),
        .result_o     (sum_res),
        .carry_o      (sum_carry),
        .ovf_o        (sum_ovf)
    );

    always_comb begin
        state_d     = state_q;
        state_d.vld = in_valid;
        if (in_valid) begin
            state_d.res = sum_res;
            if (flag_we) begin
                state_d.z = (sum_res == '0);
                state_d.n = sum_res[W-1];
                state_d.c = sum_carry;
                state_d.v = sum_ovf;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign out_valid = state_q.vld;
    assign result    = state_q.res;
    assign flag_z    = state_q.z;
    assign flag_n    = state_q.n;
    assign flag_c    = state_q.c;
    assign flag_v    = state_q.v;

    // R9
    vld_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result)));

    // R8
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && flag_we) |=> $stable({flag_z, flag_n, flag_c, flag_v}));

    // R7
    zn_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && flag_we) |=> ((flag_z == (result == '0)) && (flag_n == result[W-1])));

    // R6
    merge_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && merge) |=> (result[W-1:HALF_W] == $past(b[HALF_W-1:0])));

endmodule

// File: tb/test_hmad_unit.sv
`timescale 1ns/100ps
module test_hmad_unit;

    localparam int H = 4;
    localparam int W = 8;
    localparam int M = 255;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [W-1:0] a = '0, b = '0, c = '0;
    logic         a_hi = 1'b0, b_hi = 1'b0, a_signed = 1'b0, b_signed = 1'b0;
    logic         prod_shift = 1'b0, merge = 1'b0, flag_we = 1'b0;
    logic [2:0]   c_mode = '0;
    logic         out_valid;
    logic [W-1:0] result;
    logic         flag_z, flag_n, flag_c, flag_v;

    int errors = 0;
    int checks = 0;
    bit done = 0;
    logic [31:0] seed = 32'h1234_5678;
    int m_z = 0, m_n = 0, m_c = 0, m_v = 0;
    int last_res = 0;

    always #2.5 clk = ~clk;

    hmad_unit #(.HALF_W(H)) i_hmad_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .a(a), .b(b), .c(c),
        .a_hi(a_hi), .b_hi(b_hi), .a_signed(a_signed), .b_signed(b_signed),
        .prod_shift(prod_shift), .merge(merge), .c_mode(c_mode), .flag_we(flag_we),
        .out_valid(out_valid), .result(result),
        .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c), .flag_v(flag_v)
    );

    function automatic int rnd();
        seed = seed * 32'd1103515245 + 32'd12345;
        return int'(seed[23:16]);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic string mode_tag(input int mode, input bit mg);
        string t;
        if (mode == 3) t = "R4";
        else if (mode == 4) t = "R5";
        else t = "R3";
        return mg ? {t, "/R6/R1/R2"} : {t, "/R1/R2"};
    endfunction

    // Arithmetic model of the requirements (H=4, W=8)
    task automatic model(input int av, input int bv, input int cv, input int mode,
                         input bit ahi, input bit bhi, input bit asg, input bit bsg,
                         input bit sh, input bit mg,
                         output int res, output int cy, output int ov);
        int ha, hb, ea, eb, prod, ad, s, k;
        ha = ahi ? (av >> 4) & 15 : av & 15;
        hb = bhi ? (bv >> 4) & 15 : bv & 15;
        ea = (asg && ha >= 8) ? ha - 16 : ha;
        eb = (bsg && hb >= 8) ? hb - 16 : hb;
        prod = (ea * eb) & M;
        if (sh) prod = (prod << 4) & M;
        case (mode)
            0: ad = cv;
            1: ad = cv & 15;
            2: ad = (cv >> 4) & 15;
            3: ad = (cv + ((bv & 15) << 4)) & M;
            4: begin
                k = (ea < 0 ? 1 : 0) + (eb < 0 ? 1 : 0);
                ad = (ha == 0 || hb == 0) ? cv : ((cv - 16 * k) & M);
            end
            default: ad = 0;
        endcase
        s  = prod + ad;
        cy = (s >> 8) & 1;
        s  = s & M;
        ov = (((prod >> 7) == (ad >> 7)) && ((s >> 7) != (prod >> 7))) ? 1 : 0;
        res = mg ? (((bv & 15) << 4) | (s & 15)) : s;
    endtask

    // Called at a negedge: drive one operation, check it at the next negedge
    task automatic run_vec(input int av, input int bv, input int cv, input int mode,
                           input bit ahi, input bit bhi, input bit asg, input bit bsg,
                           input bit sh, input bit mg, input bit we);
        int er, ec, ev;
        in_valid = 1'b1;
        a = W'(av); b = W'(bv); c = W'(cv); c_mode = 3'(mode);
        a_hi = ahi; b_hi = bhi; a_signed = asg; b_signed = bsg;
        prod_shift = sh; merge = mg; flag_we = we;
        model(av, bv, cv, mode, ahi, bhi, asg, bsg, sh, mg, er, ec, ev);
        if (we) begin
            m_z = (er == 0) ? 1 : 0;
            m_n = (er >> 7) & 1;
            m_c = ec;
            m_v = ev;
        end
        @(negedge clk);
        chk(out_valid == 1'b1, "R9 out_valid", int'(out_valid), 1);
        chk(int'(result) == er, mode_tag(mode, mg), int'(result), er);
        chk({flag_z, flag_n, flag_c, flag_v} == 4'({m_z[0], m_n[0], m_c[0], m_v[0]}),
            we ? "R7 flags" : "R8 flags held",
            int'({flag_z, flag_n, flag_c, flag_v}), int'({m_z[0], m_n[0], m_c[0], m_v[0]}));
        last_res = er;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(out_valid == 1'b0, "R10 out_valid", int'(out_valid), 0);
        chk(result == '0, "R10 result", int'(result), 0);
        chk({flag_z, flag_n, flag_c, flag_v} == 4'b0, "R10 flags",
            int'({flag_z, flag_n, flag_c, flag_v}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4 R6: every control combination crossed with every addend mode
        for (int mode = 0; mode < 8; mode++) begin
            for (int ctl = 0; ctl < 64; ctl++) begin
                for (int rep = 0; rep < 8; rep++) begin
                    run_vec(rnd(), rnd(), rnd(), mode,
                            ctl[0], ctl[1], ctl[2], ctl[3], ctl[4], ctl[5], rnd() % 2 == 1);
                end
            end
        end

        // R5: all half pairs in sign-fix mode, zero halves included
        for (int ha = 0; ha < 16; ha++) begin
            for (int hb = 0; hb < 16; hb++) begin
                for (int sg = 0; sg < 4; sg++) begin
                    run_vec((rnd() << 4 | ha) & M, (ha << 4 | hb) & M, rnd(), 4,
                            1'b0, 1'b0, sg[0], sg[1], 1'b0, 1'b0, 1'b1);
                end
            end
        end

        // R8 R9: idle cycles with noise on the inputs must disturb nothing
        for (int i = 0; i < 32; i++) begin
            in_valid = 1'b0;
            flag_we = 1'b1;
            a = W'(rnd()); b = W'(rnd()); c = W'(rnd()); c_mode = 3'(rnd());
            @(negedge clk);
            chk(out_valid == 1'b0, "R9 idle out_valid", int'(out_valid), 0);
            chk(int'(result) == last_res, "R9 idle result held", int'(result), last_res);
            chk({flag_z, flag_n, flag_c, flag_v} == 4'({m_z[0], m_n[0], m_c[0], m_v[0]}),
                "R8 idle flags held", int'({flag_z, flag_n, flag_c, flag_v}),
                int'({m_z[0], m_n[0], m_c[0], m_v[0]}));
            if (i % 4 == 3) begin
                run_vec(rnd(), rnd(), rnd(), rnd() % 8, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
            end
        end

        // R7: corner sums: zero result, carry out, signed overflow
        run_vec(8'h00, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, 0, 1'b1);
        chk(flag_z == 1'b1, "R7 zero", int'(flag_z), 1);
        run_vec(8'h0F, 8'h0F, 8'hFF, 0, 0, 0, 0, 0, 0, 0, 1'b1);
        chk(flag_c == 1'b1, "R7 carry", int'(flag_c), 1);
        run_vec(8'h07, 8'h07, 8'h7F, 0, 0, 0, 1, 1, 0, 0, 1'b1);
        chk(flag_v == 1'b1, "R7 overflow", int'(flag_v), 1);

        in_valid = 1'b0;
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule